// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is the counting heart of a general-purpose timer. Each time a qualified timer tick arrives, it does exactly one thing to its count register. It clears the count, adds one to it, or subtracts one from it, depending on a clear input and a direction input. The tick is a single-cycle enable pulse in the system clock domain, supplied by an external prescaler. A 3-bit clock-select field gates that tick; a select of zero stops the timer.

The block shows two conditions of the count on separate outputs: the count is at its largest value, and the count is zero. These let a surrounding waveform unit run an up/down sequence. An overflow flag is raised by a rule chosen with a mode input, and the flag is combined with an enable to form an interrupt request.

A register-style host port can read the count at any time and write it at any time. A host write wins over any clear or step in the same cycle. All state resets synchronously to zero.

Top module: `tmr_updown_core`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `count_o` is 0, `ovf_flag_o` is 0 and `irq_o` is 0.
- R2: When a step occurs with `dir_down_i`=0 and `clr_i`=0 and no host write, `count_o` rises by one on the next clock, and 255 wraps to 0.
- R3: When a step occurs with `dir_down_i`=1 and `clr_i`=0 and no host write, `count_o` falls by one on the next clock, and 0 wraps to 255.
- R4: When a step occurs with `clr_i`=1 and no host write, `count_o` becomes 0 on the next clock, whatever `dir_down_i` is.
- R5: A step occurs only when `tick_i`=1 and `clk_sel_i` is nonzero. While `clk_sel_i`=0, or when `tick_i`=0, the count and the flag hold (unless a host write or a flag clear acts).
- R6: With `host_we_i`=1, `count_o` equals `host_wdata_i` on the next clock. This holds whatever `tick_i`, `clk_sel_i`, `clr_i` and `dir_down_i` are, and the load sets no overflow.
- R7: `at_top_o` is 1 exactly when `count_o` is 255, and `at_bottom_o` is 1 exactly when `count_o` is 0.
- R8: With `mode_updn_i`=0, `ovf_flag_o` is set on the clock where an increment step wraps the count from 255 to 0. A decrement or a clear that reaches 0 does not set it.
- R9: With `mode_updn_i`=1, `ovf_flag_o` is set on the clock where any increment or decrement step produces a count of 0. A clear or a host write to 0 does not set it.
- R10: `flag_clr_i`=1 clears `ovf_flag_o` on the next clock, unless a set event occurs in that same cycle, in which case the flag stays 1.
- R11: `irq_o` equals `ovf_flag_o` AND `irq_en_i` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Timer tick pulse from the prescaler |
| clk_sel_i | input | 3 | Clock-select field; zero stops the timer |
| dir_down_i | input | 1 | 1 = decrement, 0 = increment |
| clr_i | input | 1 | Clear count on the next step |
| mode_updn_i | input | 1 | Overflow rule: 0 = wrap from top, 1 = reaching zero |
| host_we_i | input | 1 | Host write strobe for the count |
| host_wdata_i | input | 8 | Host write data |
| flag_clr_i | input | 1 | Host write-one-to-clear of the overflow flag |
| irq_en_i | input | 1 | Interrupt enable |
| count_o | output | 8 | Current count, readable at any time |
| at_top_o | output | 1 | Count equals 255 |
| at_bottom_o | output | 1 | Count equals 0 |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The count is the only register besides the flag, so a wrong step appears on `count_o` and on `at_top_o` or `at_bottom_o` one clock after the tick that caused it. A wrong priority between a host write, a clear and a step also shows on the very next clock, as a value other than the written data. A wrong overflow decision becomes visible on `ovf_flag_o` and `irq_o` in the cycle after the wrap or the arrival at zero. It then stays visible until the host clears the flag, so the reference model, which is compared on every clock, catches it right away.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_CLEAR = 2'd2,
      OP_STEP  = 2'd3
   } cnt_op_e;
endpackage

// File: rtl/tmr_tick_gate.sv
module tmr_tick_gate #(
   parameter int SEL_W = 3
) (
   input  logic             tick_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             fire_o
);
   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("tmr_tick_gate: SEL_W must be at least 1");
      end
   endgenerate

   // any nonzero select passes the prescaler tick; zero stops the timer
   assign fire_o = tick_i & (|sel_i);
endmodule

// File: rtl/tmr_count_reg.sv
module tmr_count_reg
   import tmr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fire_i,
   input  logic             clr_i,
   input  logic             down_i,
   input  logic             we_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             wrap_up_o,
   output logic             step_zero_o
);
   localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("tmr_count_reg: WIDTH must be at least 2");
      end
   endgenerate

   cnt_op_e          op;
   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] stepped;
   logic [WIDTH-1:0] cnt_d;

   always_comb begin
      if (we_i)                op = OP_LOAD;
      else if (fire_i && clr_i) op = OP_CLEAR;
      else if (fire_i)          op = OP_STEP;
      else                      op = OP_HOLD;
   end

   assign stepped = down_i ? (cnt_q - CNT_ONE) : (cnt_q + CNT_ONE);

   always_comb begin
      unique case (op)
         OP_LOAD:  cnt_d = wdata_i;
         OP_CLEAR: cnt_d = '0;
         OP_STEP:  cnt_d = stepped;
         default:  cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
   end

   assign cnt_o       = cnt_q;
   assign wrap_up_o   = (op == OP_STEP) && !down_i && (cnt_q == CNT_MAX);
   assign step_zero_o = (op == OP_STEP) && (stepped == '0);
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic mode_updn_i,
   input  logic wrap_up_i,
   input  logic step_zero_i,
   input  logic flag_clr_i,
   input  logic irq_en_i,
   output logic flag_o,
   output logic irq_o
);
   logic flag_q;
   logic set_ev;
   logic flag_d;

   assign set_ev = mode_updn_i ? step_zero_i : wrap_up_i;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (set_ev)          flag_d = 1'b1;
            else if (flag_clr_i) flag_d = 1'b0;
            else                 flag_d = flag_q;
         end
      end else begin : g_clr_first
         always_comb begin
            if (flag_clr_i)  flag_d = 1'b0;
            else if (set_ev) flag_d = 1'b1;
            else             flag_d = flag_q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) flag_q <= 1'b0;
      else     flag_q <= flag_d;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/tmr_updown_core.sv
module tmr_updown_core #(
   parameter int WIDTH    = 8,
   parameter int SEL_W    = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic [SEL_W-1:0] clk_sel_i,
   input  logic             dir_down_i,
   input  logic             clr_i,
   input  logic             mode_updn_i,
   input  logic             host_we_i,
   input  logic [WIDTH-1:0] host_wdata_i,
   input  logic             flag_clr_i,
   input  logic             irq_en_i,
   output logic [WIDTH-1:0] count_o,
   output logic             at_top_o,
   output logic             at_bottom_o,
   output logic             ovf_flag_o,
   output logic             irq_o
);
   localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

   logic fire;
   logic wrap_up;
   logic step_zero;

   tmr_tick_gate #(.SEL_W(SEL_W)) u_gate (
      .tick_i (tick_i),
      .sel_i  (clk_sel_i),
      .fire_o (fire)
   );

   tmr_count_reg #(.WIDTH(WIDTH)) u_cnt (
      .clk         (clk),
      .rst         (rst),
      .fire_i      (fire),
      .clr_i       (clr_i),
      .down_i      (dir_down_i),
      .we_i        (host_we_i),
      .wdata_i     (host_wdata_i),
      .cnt_o       (count_o),
      .wrap_up_o   (wrap_up),
      .step_zero_o (step_zero)
   );

   tmr_ovf_flag #(.SET_WINS(SET_WINS)) u_flag (
      .clk         (clk),
      .rst         (rst),
      .mode_updn_i (mode_updn_i),
      .wrap_up_i   (wrap_up),
      .step_zero_i (step_zero),
      .flag_clr_i  (flag_clr_i),
      .irq_en_i    (irq_en_i),
      .flag_o      (ovf_flag_o),
      .irq_o       (irq_o)
   );

   assign at_top_o    = (count_o == TOP_VAL);
   assign at_bottom_o = (count_o == '0);
endmodule

// File: rtl/tmr_updown_core_chk.sv
module tmr_updown_core_chk #(
   parameter int WIDTH = 8,
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             tick_i,
   input logic [SEL_W-1:0] clk_sel_i,
   input logic             dir_down_i,
   input logic             clr_i,
   input logic             host_we_i,
   input logic [WIDTH-1:0] host_wdata_i,
   input logic [WIDTH-1:0] count_o,
   input logic             at_top_o,
   input logic             at_bottom_o,
   input logic             ovf_flag_o
);
   logic fire_s;
   assign fire_s = tick_i && (clk_sel_i != '0);

   // R6
   host_load_chk: assert property (@(posedge clk) disable iff (rst)
      host_we_i |=> (count_o == $past(host_wdata_i)));

   // R5
   stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!fire_s && !host_we_i) |=> $stable(count_o));

   // R4
   clear_bottom_chk: assert property (@(posedge clk) disable iff (rst)
      (fire_s && clr_i && !host_we_i) |=> at_bottom_o);

   // R2
   up_step_chk: assert property (@(posedge clk) disable iff (rst)
      (fire_s && !clr_i && !dir_down_i && !host_we_i) |=>
         (count_o == WIDTH'($past(count_o) + 1'b1)));

   // R7
   top_to_bottom_chk: assert property (@(posedge clk) disable iff (rst)
      (fire_s && !clr_i && !dir_down_i && !host_we_i && at_top_o) |=> at_bottom_o);

   // R5
   flag_source_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ovf_flag_o) |-> ($past(fire_s) && !$past(host_we_i) && !$past(clr_i)));
endmodule

bind tmr_updown_core tmr_updown_core_chk #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .tick_i       (tick_i),
   .clk_sel_i    (clk_sel_i),
   .dir_down_i   (dir_down_i),
   .clr_i        (clr_i),
   .host_we_i    (host_we_i),
   .host_wdata_i (host_wdata_i),
   .count_o      (count_o),
   .at_top_o     (at_top_o),
   .at_bottom_o  (at_bottom_o),
   .ovf_flag_o   (ovf_flag_o)
);

// File: tb/tmr_updown_core_bench.sv
module tmr_updown_core_bench;
   logic       clk = 1'b0;
   logic       rst;
   logic       tick_i;
   logic [2:0] clk_sel_i;
   logic       dir_down_i;
   logic       clr_i;
   logic       mode_updn_i;
   logic       host_we_i;
   logic [7:0] host_wdata_i;
   logic       flag_clr_i;
   logic       irq_en_i;
   logic [7:0] count_o;
   logic       at_top_o;
   logic       at_bottom_o;
   logic       ovf_flag_o;
   logic       irq_o;

   int errors = 0;
   int checks = 0;
   string phase = "R1";
   int m_cnt = 0;
   bit m_flag = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tmr_updown_core u_tmr_updown_core (.*);

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      int nxt;
      bit fire, set;
      if (rst) begin
         m_cnt  = 0;
         m_flag = 1'b0;
      end else begin
         fire = tick_i && (clk_sel_i != 0);
         set  = 1'b0;
         nxt  = m_cnt;
         if (host_we_i) nxt = host_wdata_i;
         else if (fire && clr_i) nxt = 0;
         else if (fire) begin
            nxt = dir_down_i ? (m_cnt + 255) % 256 : (m_cnt + 1) % 256;
            if (mode_updn_i) set = (nxt == 0);
            else             set = !dir_down_i && (m_cnt == 255);
         end
         m_cnt = nxt;
         if (set) m_flag = 1'b1;
         else if (flag_clr_i) m_flag = 1'b0;
      end
   end

   // compare away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk(phase, count_o, m_cnt);
         chk("R7", at_top_o, m_cnt == 255);
         chk("R7", at_bottom_o, m_cnt == 0);
         chk(mode_updn_i ? "R9" : "R8", ovf_flag_o, m_flag);
         chk("R11", irq_o, m_flag && irq_en_i);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1; cyc(1);
         tick_i = 1'b0; cyc(1);
      end
   endtask

   initial begin
      rst = 1'b1; tick_i = 0; clk_sel_i = 3'd1; dir_down_i = 0; clr_i = 0;
      mode_updn_i = 0; host_we_i = 0; host_wdata_i = 0; flag_clr_i = 0; irq_en_i = 1;
      cyc(3);
      chk("R1", count_o, 0);
      chk("R1", ovf_flag_o, 0);
      rst = 1'b0;
      cyc(1);
      chk("R1", irq_o, 0);

      // R2 increment through wrap, normal mode
      phase = "R2";
      run_ticks(260);
      chk("R8", ovf_flag_o, 1);
      flag_clr_i = 1; cyc(1); flag_clr_i = 0;
      phase = "R10";
      cyc(1);
      chk("R10", ovf_flag_o, 0);

      // R3 decrement through wrap, normal mode must not flag
      phase = "R3";
      dir_down_i = 1;
      run_ticks(10);
      chk("R8", ovf_flag_o, 0);

      // R4 clear with both directions
      phase = "R4";
      clr_i = 1; run_ticks(1);
      chk("R4", count_o, 0);
      host_we_i = 1; host_wdata_i = 8'd77; cyc(1); host_we_i = 0;
      dir_down_i = 0; run_ticks(1); clr_i = 0;
      chk("R4", count_o, 0);

      // R5 stopped timer ignores ticks
      phase = "R5";
      run_ticks(3);
      clk_sel_i = 0;
      run_ticks(20);
      chk("R5", count_o, 3);
      clk_sel_i = 3'd5;

      // R6 host write against clear and step, and while stopped
      phase = "R6";
      host_we_i = 1; host_wdata_i = 8'd200; tick_i = 1; clr_i = 1; cyc(1);
      host_we_i = 0; tick_i = 0; clr_i = 0; cyc(1);
      chk("R6", count_o, 200);
      clk_sel_i = 0;
      host_we_i = 1; host_wdata_i = 8'd255; cyc(1); host_we_i = 0;
      chk("R6", count_o, 255);
      clk_sel_i = 3'd7;
      chk("R7", at_top_o, 1);

      // R9 up/down mode: reaching zero by decrement and by increment
      phase = "R9";
      mode_updn_i = 1;
      run_ticks(1);
      chk("R9", ovf_flag_o, 1);
      flag_clr_i = 1; cyc(1); flag_clr_i = 0;
      host_we_i = 1; host_wdata_i = 8'd3; cyc(1); host_we_i = 0;
      dir_down_i = 1;
      run_ticks(2);
      chk("R9", ovf_flag_o, 0);
      // R10 clear request and set event in the same cycle: set wins
      flag_clr_i = 1; tick_i = 1; cyc(1); flag_clr_i = 0; tick_i = 0; cyc(1);
      chk("R10", ovf_flag_o, 1);
      chk("R9", count_o, 0);
      run_ticks(300);
      flag_clr_i = 1; cyc(1); flag_clr_i = 0;
      // clear and host write to zero do not flag
      host_we_i = 1; host_wdata_i = 8'd0; cyc(1); host_we_i = 0;
      clr_i = 1; run_ticks(2); clr_i = 0;
      chk("R9", ovf_flag_o, 0);

      // R11 enable masks request
      phase = "R11";
      dir_down_i = 1; run_ticks(1); dir_down_i = 0; run_ticks(1);
      irq_en_i = 0; cyc(2);
      chk("R11", irq_o, 0);
      irq_en_i = 1; cyc(1);
      chk("R11", irq_o, 1);
      mode_updn_i = 0; dir_down_i = 1; clk_sel_i = 3'd2;
      run_ticks(40);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule